// File: doc/BRIEF.md
# Real-Mode Address Translation Unit

This unit decides what happens to a memory access when address relocation is switched off for it. An access arrives with an access kind, the two relocate enables, a hypervisor-state flag, three partition control fields and two 64-bit offset registers. When the access is not in real mode, the unit only reports that the normal segment lookup path applies.

In real mode the top four address bits are always cleared first. A hypervisor access is then combined with the hypervisor offset. A guest access takes one of two paths:

- It is checked against a decoded size limit and combined with the guest offset.
- It is turned into a synthesized segment descriptor that an external hash-table walker consumes.

An access outside the limit produces an instruction or data storage fault with precise status bits.

A request is taken when `req_valid` and `req_ready` are both high. Exactly one cycle later a registered response appears for one cycle. Offsets are merged by bitwise OR, never by addition.

Top module: `rm_xlate`

## Requirements
- R1: After reset `rsp_valid` and every response field are 0, and they stay 0 until the first accepted request. `req_ready` is 1 once reset is released.
- R2: A request accepted at a clock edge gives `rsp_valid`=1 after the next edge, for exactly one cycle. With no accepted request, `rsp_valid` is 0.
- R3: Access kinds are 0 load, 1 store and 2 fetch. An access is in real mode when it is a fetch with `req_ir`=0, or a load or store with `req_dr`=0. Otherwise the response has `rsp_kind`=3 (lookup path) with `rsp_addr`=`req_ea` and all other fields 0.
- R4: Access kind 3 gives `rsp_err`=1 and `rsp_kind`=1, with no fault flags and all address, descriptor and status fields 0.
- R5: Result kinds are 0 real address, 1 fault, 2 walker handoff and 3 lookup path. In real mode the masked address M is `req_ea` with bits 63:60 cleared. With `req_hv`=1 and `req_ea[63]`=0, the response is kind 0 with `rsp_addr` = M OR `hyp_off`.
- R6: With `req_hv`=1 and `req_ea[63]`=1, the response is kind 0 with `rsp_addr`=M, and no limit check is made.
- R7: With `req_hv`=0 and `pc_vrm`=1, the response is kind 2 with `rsp_addr`=M and `rsp_desc_v`=1. `rsp_desc` = 0x4001FFFFFF000000 OR ((`pc_pgsel`<<4) AND 0x130).
- R8: Limit codes decode as follows, and every other code gives 0:

  | Code | Limit |
  |------|-------|
  | 0x1 | 16 GB |
  | 0x2 | 1 GB |
  | 0x3 | 64 MB |
  | 0x4 | 256 MB |
  | 0x7 | 128 MB |
  | 0x8 | 32 MB |
- R9: With `req_hv`=0, `pc_vrm`=0 and M strictly below the limit, the response is kind 0 with `rsp_addr` = M OR `gst_off`.
- R10: An out-of-limit guest fetch gives kind 1, `rsp_isi`=1, `rsp_status`=0x08000000 and `rsp_far`=0.
- R11: An out-of-limit guest load gives kind 1, `rsp_dsi`=1, `rsp_status`=0x08000000 and `rsp_far`=`req_ea` unmasked. A store gives the same with `rsp_status`=0x0A000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can take a request |
| req_acc | input | 2 | Access kind |
| req_ea | input | 64 | Effective address |
| req_ir | input | 1 | Instruction relocate enable |
| req_dr | input | 1 | Data relocate enable |
| req_hv | input | 1 | Hypervisor state |
| pc_vrm | input | 1 | Guest real mode goes through the walker |
| pc_pgsel | input | 5 | Page-size selector for the descriptor |
| pc_limcode | input | 4 | Guest real-mode size code |
| hyp_off | input | 64 | Hypervisor offset |
| gst_off | input | 64 | Guest offset |
| rsp_valid | output | 1 | Response present |
| rsp_kind | output | 2 | Result kind |
| rsp_err | output | 1 | Illegal access kind |
| rsp_addr | output | 64 | Real or passthrough address |
| rsp_desc | output | 64 | Synthesized descriptor word |
| rsp_desc_v | output | 1 | Descriptor valid bit |
| rsp_isi | output | 1 | Instruction storage fault |
| rsp_dsi | output | 1 | Data storage fault |
| rsp_status | output | 32 | Fault status |
| rsp_far | output | 64 | Fault address |

## Verification
The assertions assume that request inputs are meaningful only in the cycle they are accepted. They also assume the partition fields and offsets hold steady within that cycle, so every response property is tied to `$past` of the accepted inputs. The stimulus changes every input on the falling edge and holds `req_valid` for exactly one rising edge per request. Each request is followed by one idle cycle, so every response can be matched to one accepted request. The sweep covers every access kind, relocate setting, privilege state, walker setting and limit code. For each, it uses addresses at zero, at the limit, just below the limit, with the top bits set, and with bits that overlap the offsets.

// File: rtl/rm_xlate.sv
module rm_xlate #(
  parameter int AW = 64,
  parameter int SW = 32,
  parameter int SELW = 5,
  parameter int CODEW = 4,
  parameter logic [AW-1:0] VRM_VSID = 64'h0001_FFFF_FF00_0000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [1:0]      req_acc,
  input  logic [AW-1:0]   req_ea,
  input  logic            req_ir,
  input  logic            req_dr,
  input  logic            req_hv,
  input  logic            pc_vrm,
  input  logic [SELW-1:0] pc_pgsel,
  input  logic [CODEW-1:0] pc_limcode,
  input  logic [AW-1:0]   hyp_off,
  input  logic [AW-1:0]   gst_off,
  output logic            rsp_valid,
  output logic [1:0]      rsp_kind,
  output logic            rsp_err,
  output logic [AW-1:0]   rsp_addr,
  output logic [AW-1:0]   rsp_desc,
  output logic            rsp_desc_v,
  output logic            rsp_isi,
  output logic            rsp_dsi,
  output logic [SW-1:0]   rsp_status,
  output logic [AW-1:0]   rsp_far
);
  localparam logic [1:0] K_REAL = 2'd0, K_FAULT = 2'd1, K_WALK = 2'd2, K_XON = 2'd3;
  localparam logic [AW-1:0] SEG_1T = AW'(1) << (AW-2);
  localparam logic [AW-1:0] LP_MASK = AW'(12'h130);
  localparam logic [SW-1:0] ST_BOUND = SW'(32'h0800_0000);
  localparam logic [SW-1:0] ST_STORE = SW'(32'h0200_0000);

  wire accept   = req_valid && req_ready;
  wire is_fetch = req_acc == 2'd2;
  wire illegal  = req_acc == 2'd3;
  wire realm    = is_fetch ? !req_ir : !req_dr;
  wire [AW-1:0] ea_m = {4'b0000, req_ea[AW-5:0]};

  logic [AW-1:0] limit;
  always_comb begin
    case (pc_limcode)
      4'h8:    limit = AW'(1) << 25;
      4'h3:    limit = AW'(1) << 26;
      4'h7:    limit = AW'(1) << 27;
      4'h4:    limit = AW'(1) << 28;
      4'h2:    limit = AW'(1) << 30;
      4'h1:    limit = AW'(1) << 34;
      default: limit = '0;
    endcase
  end

  logic [1:0] n_kind;
  logic n_err, n_dv, n_isi, n_dsi;
  logic [AW-1:0] n_addr, n_desc, n_far;
  logic [SW-1:0] n_st;

  always_comb begin
    n_kind = K_REAL; n_err = 1'b0; n_dv = 1'b0; n_isi = 1'b0; n_dsi = 1'b0;
    n_addr = '0; n_desc = '0; n_far = '0; n_st = '0;
    if (illegal) begin
      n_kind = K_FAULT;
      n_err  = 1'b1;
    end else if (!realm) begin
      n_kind = K_XON;
      n_addr = req_ea;
    end else if (req_hv) begin
      n_addr = req_ea[AW-1] ? ea_m : (ea_m | hyp_off);
    end else if (pc_vrm) begin
      n_kind = K_WALK;
      n_addr = ea_m;
      n_desc = VRM_VSID | SEG_1T | ((AW'(pc_pgsel) << 4) & LP_MASK);
      n_dv   = 1'b1;
    end else if (ea_m < limit) begin
      n_addr = ea_m | gst_off;
    end else begin
      n_kind = K_FAULT;
      n_st   = ST_BOUND;
      if (is_fetch) n_isi = 1'b1;
      else begin
        n_dsi = 1'b1;
        n_far = req_ea;
        if (req_acc == 2'd1) n_st = ST_BOUND | ST_STORE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_ready  <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_kind   <= '0;
      rsp_err    <= 1'b0;
      rsp_addr   <= '0;
      rsp_desc   <= '0;
      rsp_desc_v <= 1'b0;
      rsp_isi    <= 1'b0;
      rsp_dsi    <= 1'b0;
      rsp_status <= '0;
      rsp_far    <= '0;
    end else begin
      req_ready <= 1'b1;
      rsp_valid <= accept;
      if (accept) begin
        rsp_kind   <= n_kind;
        rsp_err    <= n_err;
        rsp_addr   <= n_addr;
        rsp_desc   <= n_desc;
        rsp_desc_v <= n_dv;
        rsp_isi    <= n_isi;
        rsp_dsi    <= n_dsi;
        rsp_status <= n_st;
        rsp_far    <= n_far;
      end
    end
  end
endmodule

// File: rtl/rm_xlate_chk.sv
module rm_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [1:0]  req_acc,
  input logic [63:0] req_ea,
  input logic        req_ir,
  input logic        req_dr,
  input logic        req_hv,
  input logic        rsp_valid,
  input logic [1:0]  rsp_kind,
  input logic        rsp_err,
  input logic [63:0] rsp_addr,
  input logic        rsp_isi,
  input logic        rsp_dsi,
  input logic [31:0] rsp_status,
  input logic [63:0] rsp_far
);
  wire acc_ok = req_valid && req_ready;
  wire rm = (req_acc == 2'd2) ? !req_ir : !req_dr;

  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) acc_ok |=> rsp_valid); // R2
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n) !acc_ok |=> !rsp_valid); // R2
  AST_ILLEGAL_ERR: assert property (@(posedge clk) disable iff (!rst_n) acc_ok && req_acc == 2'd3 |=> rsp_err && !rsp_isi && !rsp_dsi); // R4
  AST_XON_PASS: assert property (@(posedge clk) disable iff (!rst_n) acc_ok && req_acc != 2'd3 && !rm |=> rsp_kind == 2'd3 && rsp_addr == $past(req_ea)); // R3
  AST_HV_NOFAULT: assert property (@(posedge clk) disable iff (!rst_n) acc_ok && req_acc != 2'd3 && rm && req_hv |=> rsp_kind == 2'd0 && !rsp_isi && !rsp_dsi); // R6
  AST_ISI_FETCH: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid && rsp_isi |-> rsp_status == 32'h0800_0000 && !rsp_dsi); // R10
  AST_DSI_FAR: assert property (@(posedge clk) disable iff (!rst_n) acc_ok ##1 (rsp_valid && rsp_dsi) |-> rsp_far == $past(req_ea)); // R11
endmodule

bind rm_xlate rm_xlate_chk u_chk (.*);

// File: tb/rm_xlate_tb.sv
`timescale 1ns/1ps
module rm_xlate_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_acc = '0;
  logic [63:0] req_ea = '0;
  logic req_ir = 1'b0, req_dr = 1'b0, req_hv = 1'b0, pc_vrm = 1'b0;
  logic [4:0] pc_pgsel = '0;
  logic [3:0] pc_limcode = '0;
  logic [63:0] hyp_off = 64'h0000_0000_0300_1000;
  logic [63:0] gst_off = 64'h0000_0000_0100_0F00;
  logic rsp_valid, rsp_err, rsp_desc_v, rsp_isi, rsp_dsi;
  logic [1:0] rsp_kind;
  logic [63:0] rsp_addr, rsp_desc, rsp_far;
  logic [31:0] rsp_status;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  rm_xlate u_dut (.*);

  function automatic logic [63:0] lim_of(input logic [3:0] c);
    case (c)
      4'h1: return 64'd16 << 30;
      4'h2: return 64'd1 << 30;
      4'h3: return 64'd64 << 20;
      4'h4: return 64'd256 << 20;
      4'h7: return 64'd128 << 20;
      4'h8: return 64'd32 << 20;
      default: return 64'd0;
    endcase
  endfunction

  task automatic check_out(input string tag, input logic [1:0] k, input logic e,
                           input logic [63:0] a, input logic [63:0] d, input logic dv,
                           input logic i, input logic ds, input logic [31:0] st, input logic [63:0] f);
    checks++;
    if (!(rsp_valid && rsp_kind == k && rsp_err == e && rsp_addr == a && rsp_desc == d &&
          rsp_desc_v == dv && rsp_isi == i && rsp_dsi == ds && rsp_status == st && rsp_far == f)) begin
      errors++;
      $display("FAIL %s: got v=%0b k=%0d e=%0b a=%h d=%h dv=%0b i=%0b ds=%0b st=%h f=%h exp v=1 k=%0d e=%0b a=%h d=%h dv=%0b i=%0b ds=%0b st=%h f=%h",
               tag, rsp_valid, rsp_kind, rsp_err, rsp_addr, rsp_desc, rsp_desc_v, rsp_isi, rsp_dsi,
               rsp_status, rsp_far, k, e, a, d, dv, i, ds, st, f);
    end
  endtask

  task automatic run_one();
    logic [63:0] m;
    logic rm;
    m = {4'h0, req_ea[59:0]};
    rm = (req_acc == 2'd2) ? !req_ir : !req_dr;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (req_acc == 2'd3) check_out("R4", 2'd1, 1'b1, 0, 0, 0, 0, 0, 0, 0);
    else if (!rm) check_out("R3", 2'd3, 0, req_ea, 0, 0, 0, 0, 0, 0);
    else if (req_hv && !req_ea[63]) check_out("R5", 2'd0, 0, m | hyp_off, 0, 0, 0, 0, 0, 0);
    else if (req_hv) check_out("R6", 2'd0, 0, m, 0, 0, 0, 0, 0, 0);
    else if (pc_vrm)
      check_out("R7", 2'd2, 0, m, 64'h4001_FFFF_FF00_0000 | ((64'(pc_pgsel) << 4) & 64'h130), 1'b1, 0, 0, 0, 0);
    else if (m < lim_of(pc_limcode)) check_out("R9 R8", 2'd0, 0, m | gst_off, 0, 0, 0, 0, 0, 0);
    else if (req_acc == 2'd2) check_out("R10 R8", 2'd1, 0, 0, 0, 0, 1'b1, 0, 32'h0800_0000, 0);
    else check_out("R11 R8", 2'd1, 0, 0, 0, 0, 0, 1'b1,
                   (req_acc == 2'd1) ? 32'h0A00_0000 : 32'h0800_0000, req_ea);
    @(negedge clk);
    checks++;
    if (rsp_valid) begin
      errors++;
      $display("FAIL R2: rsp_valid=%0b exp 0 after idle cycle", rsp_valid);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung, got timeout exp completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (rsp_valid || rsp_kind != 0 || rsp_addr != 0 || rsp_isi || rsp_dsi || rsp_err || rsp_status != 0) begin
      errors++;
      $display("FAIL R1: outputs not cleared in reset, got v=%0b a=%h exp 0", rsp_valid, rsp_addr);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (rsp_valid || !req_ready || rsp_addr != 0 || rsp_kind != 0) begin
      errors++;
      $display("FAIL R1: before first request got v=%0b rdy=%0b a=%h exp v=0 rdy=1 a=0", rsp_valid, req_ready, rsp_addr);
    end
    for (int acc = 0; acc < 4; acc++)
      for (int fl = 0; fl < 16; fl++)
        for (int c = 0; c < 16; c++)
          for (int k = 0; k < 6; k++) begin
            logic [63:0] l;
            req_acc = acc[1:0];
            req_ir = fl[0]; req_dr = fl[1]; req_hv = fl[2]; pc_vrm = fl[3];
            pc_limcode = c[3:0];
            pc_pgsel = 5'(c * 3 + k);
            l = lim_of(c[3:0]);
            case (k)
              0: req_ea = 64'd0;
              1: req_ea = (l == 0) ? 64'd0 : l - 1;
              2: req_ea = l;
              3: req_ea = 64'hF000_0000_0000_0000 | ((l == 0) ? 64'd5 : l - 1);
              4: req_ea = 64'h7FFF_FFFF_FFFF_FFFF;
              default: req_ea = 64'h0000_0000_0123_1F0F;
            endcase
            run_one();
          end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule